// File: doc/BRIEF.md
# Memory Window Bank-Switch Decoder

This block sits on the bus of a processor with a 20-bit memory address and an 8-bit data bus. It steers each memory cycle to one of two memories. One is a 1 MB main memory. The other is a 512 KB secondary memory that serves as a RAM disk.

The secondary memory is split into eight 64 KB pages. Any one page is visible through a fixed 64 KB window at processor addresses 0xE0000 to 0xEFFFF. Memory cycles that fall inside the window go to the secondary memory and never to main memory. All other memory cycles go to main memory.

Software picks the visible page by writing to a page register at I/O port 0x55, and can read the register back through the same port. The chip selects and addresses are formed combinationally in the same cycle as the bus request. A page write takes effect at the clock edge that ends the write cycle, so the next access already sees the new page.

Top module: `mwin_bank_decoder`

## Requirements
- R1: A memory cycle (`cpu_mem_io`=1 with `cpu_rd` or `cpu_wr` high) whose address bits 19:16 equal 0xE asserts `sec_cs` and keeps `main_cs` low in that same cycle.
- R2: A memory cycle outside 0xE0000–0xEFFFF asserts `main_cs` and keeps `sec_cs` low; `main_addr` always equals `cpu_addr`.
- R3: `main_cs` and `sec_cs` are never high together, and both stay low during I/O cycles (`cpu_mem_io`=0) and when neither strobe is high.
- R4: `sec_addr` (19 bits) always equals {page[2:0], `cpu_addr`[15:0]}.
- R5: An I/O write (`cpu_mem_io`=0, `cpu_wr`=1) with `cpu_addr`[15:0]=0x0055 loads the page register from `cpu_wdata`[2:0] at that clock edge; bits 7:3 of the data are ignored; the new page applies from the next cycle.
- R6: An I/O read (`cpu_mem_io`=0, `cpu_rd`=1) of port 0x0055 drives `io_hit`=1 and `io_rdata`={5'b0, page}; in every other cycle `io_hit`=0 and `io_rdata`=0.
- R7: A memory write to address 0x00055 leaves the page register unchanged.
- R8: An I/O write to any port other than 0x0055 leaves the page register unchanged.
- R9: A synchronous active-high `rst` clears the page register to 0; `rst` takes priority over a simultaneous port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 20 | Processor address (I/O port number in bits 15:0) |
| cpu_mem_io | input | 1 | Cycle type: 1 = memory, 0 = I/O |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| cpu_wdata | input | 8 | Processor write data |
| main_cs | output | 1 | Main memory select |
| main_addr | output | 20 | Main memory address |
| sec_cs | output | 1 | Secondary memory select |
| sec_addr | output | 19 | Secondary memory address |
| io_hit | output | 1 | Page register is being read on the I/O bus |
| io_rdata | output | 8 | Page register read-back data |

## Verification
The bench probes both window edges, 0xDFFFF and 0xF0000 against 0xE0000 and 0xEFFFF. A tag compare that is off by one nibble would route those addresses to the wrong memory.

It writes bytes with the upper bits set and reads them back. A register that kept more than three bits would return a nonzero upper field or put a wrong page on the secondary address.

A memory write to 0x00055 and an I/O write to a neighbouring port are each followed by a read-back. A decoder that ignores the M/IO qualifier, or that matches the port too loosely, would corrupt the page there. A reset asserted together with a port write checks that reset wins.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

   // Classified bus cycle, shared by decode, page register and routing.
   typedef struct packed {
      logic mem_acc;   // memory cycle with a strobe
      logic in_win;    // address tag hits the window
      logic port_rd;   // I/O read of the page port
      logic port_wr;   // I/O write of the page port
   } mwin_cyc_t;

endpackage

// File: rtl/mwin_cycle_decode.sv
module mwin_cycle_decode
   import mwin_pkg::*;
#(
   parameter int                ADDR_W    = 20,
   parameter int                WIN_W     = 16,
   parameter int                IO_W      = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hE0000,
   parameter logic [IO_W-1:0]   PORT_ADDR = 16'h0055
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              mem_io,
   input  logic              rd,
   input  logic              wr,
   output mwin_cyc_t         cyc
);
   localparam int TAG_W = ADDR_W - WIN_W;

   logic [TAG_W-1:0] tag_base;
   logic             strobe;

   assign tag_base = WIN_BASE[ADDR_W-1 -: TAG_W];
   assign strobe   = rd | wr;

   always_comb begin
      cyc.mem_acc = mem_io & strobe;
      cyc.in_win  = (addr[ADDR_W-1 -: TAG_W] == tag_base);
      cyc.port_rd = ~mem_io & rd & (addr[IO_W-1:0] == PORT_ADDR);
      cyc.port_wr = ~mem_io & wr & (addr[IO_W-1:0] == PORT_ADDR);
   end
endmodule

// File: rtl/mwin_page_reg.sv
module mwin_page_reg
   import mwin_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  mwin_cyc_t         cyc,
   input  logic [DATA_W-1:0] wdata,
   output logic [PAGE_W-1:0] page
);
   always_ff @(posedge clk) begin
      if (rst)              page <= '0;
      else if (cyc.port_wr) page <= wdata[PAGE_W-1:0];
   end
endmodule

// File: rtl/mwin_route.sv
module mwin_route
   import mwin_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int WIN_W  = 16,
   parameter int PAGE_W = 3
) (
   input  mwin_cyc_t                  cyc,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [PAGE_W-1:0]          page,
   output logic                       main_cs,
   output logic [ADDR_W-1:0]          main_addr,
   output logic                       sec_cs,
   output logic [PAGE_W+WIN_W-1:0]    sec_addr
);
   always_comb begin
      main_cs   = cyc.mem_acc & ~cyc.in_win;
      sec_cs    = cyc.mem_acc &  cyc.in_win;
      main_addr = addr;
      sec_addr  = {page, addr[WIN_W-1:0]};
   end
endmodule

// File: rtl/mwin_readback.sv
module mwin_readback
   import mwin_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 3,
   parameter bit READ_BACK = 1'b1
) (
   input  mwin_cyc_t         cyc,
   input  logic [PAGE_W-1:0] page,
   output logic              hit,
   output logic [DATA_W-1:0] rdata
);
   localparam int PAD_W = DATA_W - PAGE_W;

   generate
      if (READ_BACK) begin : g_mux
         always_comb begin
            hit   = cyc.port_rd;
            rdata = cyc.port_rd ? {{PAD_W{1'b0}}, page} : '0;
         end
      end else begin : g_none
         always_comb begin
            hit   = 1'b0;
            rdata = '0;
         end
      end
   endgenerate
endmodule

// File: rtl/mwin_bank_decoder.sv
module mwin_bank_decoder
   import mwin_pkg::*;
#(
   parameter int                ADDR_W    = 20,
   parameter int                DATA_W    = 8,
   parameter int                WIN_W     = 16,
   parameter int                PAGE_W    = 3,
   parameter int                IO_W      = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hE0000,
   parameter logic [IO_W-1:0]   PORT_ADDR = 16'h0055,
   parameter bit                READ_BACK = 1'b1,
   localparam int               SEC_W     = PAGE_W + WIN_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_mem_io,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              main_cs,
   output logic [ADDR_W-1:0] main_addr,
   output logic              sec_cs,
   output logic [SEC_W-1:0]  sec_addr,
   output logic              io_hit,
   output logic [DATA_W-1:0] io_rdata
);
   generate
      if (WIN_W >= ADDR_W) begin : g_bad_win
         $error("window must be smaller than the address space");
      end
      if (PAGE_W >= DATA_W) begin : g_bad_page
         $error("page field must be narrower than the data bus");
      end
      if (IO_W > ADDR_W) begin : g_bad_io
         $error("I/O port width exceeds the address width");
      end
      if (WIN_BASE[WIN_W-1:0] != '0) begin : g_bad_base
         $error("window base must be aligned to the window size");
      end
   endgenerate

   mwin_cyc_t         cyc;
   logic [PAGE_W-1:0] page_q;

   mwin_cycle_decode #(
      .ADDR_W(ADDR_W), .WIN_W(WIN_W), .IO_W(IO_W),
      .WIN_BASE(WIN_BASE), .PORT_ADDR(PORT_ADDR)
   ) u_dec (
      .addr(cpu_addr), .mem_io(cpu_mem_io), .rd(cpu_rd), .wr(cpu_wr), .cyc(cyc)
   );

   mwin_page_reg #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_page (
      .clk(clk), .rst(rst), .cyc(cyc), .wdata(cpu_wdata), .page(page_q)
   );

   mwin_route #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .PAGE_W(PAGE_W)) u_route (
      .cyc(cyc), .addr(cpu_addr), .page(page_q),
      .main_cs(main_cs), .main_addr(main_addr),
      .sec_cs(sec_cs), .sec_addr(sec_addr)
   );

   mwin_readback #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .READ_BACK(READ_BACK)) u_rb (
      .cyc(cyc), .page(page_q), .hit(io_hit), .rdata(io_rdata)
   );
endmodule

// File: rtl/mwin_bank_decoder_chk.sv
module mwin_bank_decoder_chk #(
   parameter int                ADDR_W    = 20,
   parameter int                DATA_W    = 8,
   parameter int                WIN_W     = 16,
   parameter int                PAGE_W    = 3,
   parameter int                IO_W      = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 20'hE0000,
   parameter logic [IO_W-1:0]   PORT_ADDR = 16'h0055
) (
   input logic                    clk,
   input logic                    rst,
   input logic [ADDR_W-1:0]       cpu_addr,
   input logic                    cpu_mem_io,
   input logic                    cpu_rd,
   input logic                    cpu_wr,
   input logic [DATA_W-1:0]       cpu_wdata,
   input logic                    main_cs,
   input logic                    sec_cs,
   input logic [PAGE_W+WIN_W-1:0] sec_addr,
   input logic                    io_hit,
   input logic [DATA_W-1:0]       io_rdata,
   input logic [PAGE_W-1:0]       page_q
);
   localparam int TAG_W = ADDR_W - WIN_W;

   logic mem_cyc, win_hit, port_wr;
   assign mem_cyc = cpu_mem_io && (cpu_rd || cpu_wr);
   assign win_hit = cpu_addr[ADDR_W-1 -: TAG_W] == WIN_BASE[ADDR_W-1 -: TAG_W];
   assign port_wr = !cpu_mem_io && cpu_wr && cpu_addr[IO_W-1:0] == PORT_ADDR;

   p_win_sec_r1: assert property (@(posedge clk) disable iff (rst)
      (mem_cyc && win_hit) |-> (sec_cs && !main_cs));

   p_out_main_r2: assert property (@(posedge clk) disable iff (rst)
      (mem_cyc && !win_hit) |-> (main_cs && !sec_cs));

   p_excl_r3: assert property (@(posedge clk) disable iff (rst)
      $countones({main_cs, sec_cs}) <= 1);

   p_idle_r3: assert property (@(posedge clk) disable iff (rst)
      !mem_cyc |-> (!main_cs && !sec_cs));

   p_sec_addr_r4: assert property (@(posedge clk) disable iff (rst)
      sec_cs |-> sec_addr == {page_q, cpu_addr[WIN_W-1:0]});

   p_load_r5: assert property (@(posedge clk) disable iff (rst)
      port_wr |=> page_q == $past(cpu_wdata[PAGE_W-1:0]));

   p_rdback_r6: assert property (@(posedge clk) disable iff (rst)
      io_hit |-> io_rdata == {{(DATA_W-PAGE_W){1'b0}}, page_q});

   p_nohit_r6: assert property (@(posedge clk) disable iff (rst)
      !io_hit |-> io_rdata == '0);

   p_hold_r7_r8: assert property (@(posedge clk) disable iff (rst)
      !port_wr |=> $stable(page_q));

   p_reset_r9: assert property (@(posedge clk)
      rst |=> page_q == '0);
endmodule

bind mwin_bank_decoder mwin_bank_decoder_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .PAGE_W(PAGE_W),
   .IO_W(IO_W), .WIN_BASE(WIN_BASE), .PORT_ADDR(PORT_ADDR)
) u_chk (
   .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_mem_io(cpu_mem_io),
   .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
   .main_cs(main_cs), .sec_cs(sec_cs), .sec_addr(sec_addr),
   .io_hit(io_hit), .io_rdata(io_rdata), .page_q(page_q)
);

// File: tb/mwin_bank_decoder_test.sv
`timescale 1ns/1ps
module mwin_bank_decoder_test;
   localparam real PERIOD = 20.0;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [19:0] cpu_addr = '0;
   logic        cpu_mem_io = 1'b0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic        main_cs, sec_cs, io_hit;
   logic [19:0] main_addr;
   logic [18:0] sec_addr;
   logic [7:0]  io_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   int ref_page = 0;
   bit done     = 0;

   always #(PERIOD/2) clk = ~clk;

   mwin_bank_decoder uut (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_mem_io(cpu_mem_io),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .main_cs(main_cs), .main_addr(main_addr), .sec_cs(sec_cs),
      .sec_addr(sec_addr), .io_hit(io_hit), .io_rdata(io_rdata)
   );

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // One bus cycle: drive after the falling edge, compare mid-low-phase,
   // then advance the reference model at the rising edge.
   task automatic cycle(input bit r, input bit mio, input bit rd, input bit wr,
                        input int addr, input int wd, input string req);
      bit mem, win, hit, pwr;
      @(negedge clk);
      rst = r; cpu_mem_io = mio; cpu_rd = rd; cpu_wr = wr;
      cpu_addr = 20'(addr); cpu_wdata = 8'(wd);
      #2;
      mem = mio && (rd || wr);
      win = ((addr >> 16) & 'hF) == 'hE;
      hit = !mio && rd && ((addr & 'hFFFF) == 'h55);
      pwr = !mio && wr && ((addr & 'hFFFF) == 'h55);
      check({req, "/R1"}, "sec_cs",  sec_cs,  mem && win);
      check({req, "/R2"}, "main_cs", main_cs, mem && !win);
      check({req, "/R2"}, "main_addr", main_addr, addr & 'hFFFFF);
      check({req, "/R3"}, "both_cs", main_cs && sec_cs, 0);
      check({req, "/R4"}, "sec_addr", sec_addr, (ref_page << 16) | (addr & 'hFFFF));
      check({req, "/R6"}, "io_hit",  io_hit,  hit);
      check({req, "/R6"}, "io_rdata", io_rdata, hit ? ref_page : 0);
      @(posedge clk);
      if (r)        ref_page = 0;
      else if (pwr) ref_page = wd & 7;
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      // R9: reset state, read back during reset
      cycle(1, 0, 1, 0, 'h00055, 0, "R9");
      cycle(1, 0, 0, 1, 'h00055, 'h07, "R9");   // reset beats port write
      cycle(0, 0, 1, 0, 'h00055, 0, "R9");
      // R1/R2: window edges with page 0
      cycle(0, 1, 1, 0, 'h00000, 0, "R2");
      cycle(0, 1, 1, 0, 'hDFFFF, 0, "R2");
      cycle(0, 1, 1, 0, 'hE0000, 0, "R1");
      cycle(0, 1, 0, 1, 'hEFFFF, 0, "R1");
      cycle(0, 1, 0, 1, 'hF0000, 0, "R2");
      cycle(0, 1, 1, 0, 'hFFFFF, 0, "R2");
      // R3: idle and I/O cycles select no memory
      cycle(0, 1, 0, 0, 'hE1234, 0, "R3");
      cycle(0, 0, 1, 0, 'hE1234, 0, "R3");
      // R5: write with upper bits set, then use the page
      cycle(0, 0, 0, 1, 'h00055, 'hFD, "R5");
      cycle(0, 1, 1, 0, 'hE1234, 0, "R5");
      cycle(0, 0, 1, 0, 'h00055, 0, "R5");
      // R7: memory write to 0x00055 is not a port write
      cycle(0, 1, 0, 1, 'h00055, 'h02, "R7");
      cycle(0, 0, 1, 0, 'h00055, 0, "R7");
      // R8: neighbouring and aliased ports
      cycle(0, 0, 0, 1, 'h00054, 'h03, "R8");
      cycle(0, 0, 0, 1, 'h00155, 'h03, "R8");
      cycle(0, 0, 0, 1, 'h10056, 'h03, "R8");
      cycle(0, 0, 1, 0, 'h00055, 0, "R8");
      cycle(0, 1, 1, 0, 'hEABCD, 0, "R8");
      // R4/R5: every page through the window
      for (int p = 0; p < 8; p++) begin
         cycle(0, 0, 0, 1, 'h00055, (p << 3) | p | 'h80, "R5");
         cycle(0, 1, 1, 0, 'hE0000 | (p * 'h1111), 0, "R4");
         cycle(0, 0, 1, 0, 'h00055, 0, "R6");
      end
      // R6: I/O read of another port
      cycle(0, 0, 1, 0, 'h00056, 0, "R6");
      // R9: reset mid-run
      cycle(1, 1, 1, 0, 'hE0001, 0, "R9");
      cycle(0, 1, 1, 0, 'hE0001, 0, "R9");
      cycle(0, 0, 1, 0, 'h00055, 0, "R9");
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule